// File: doc/BRIEF.md
# Short-Address-Mode DMA Channel

A single DMA channel that moves data between a stepping memory address and a fixed I/O address. It is loaded once with a control byte, a start memory address, an I/O address, a transfer count and a mode flag. It then waits for the trigger that its 4-bit source code selects. The trigger can be one of eleven peripheral event strobes or an external active-low request pin, sensed on the falling edge or on the low level. Each trigger starts one transfer.

In dual address mode a transfer is a read cycle followed by a write cycle, and the data read is written back out. In single address mode a transfer is one bus cycle at the memory address, with an active-low acknowledge strobe that lets the external device drive or take the data. After each transfer the memory address steps by the transfer size and the count drops. When the count runs out, sequential mode stops the channel and raises a done pulse. Repeat mode instead restores the start address and the count and keeps running.

Top module: `dma_short_chan`

## Requirements
- R1: After reset `bus_req` and `done_irq` are 0, `ack_n` is 1 and `chan_en` is 0. The cleared control byte has source code 0000, so no strobe starts a transfer.
- R2: A cycle with `setup_we` high loads the control byte, the addresses, the count and the single/dual flag, and sets `chan_en`. Control byte layout: bit 7 is size (1 = 16-bit word), bit 6 is step (1 = decrement), bit 5 is repeat, bit 4 is direction, bits 3:0 are the source code.
- R3: In dual address mode with direction 0, a transfer reads at the memory address in one cycle. In the next cycle it writes at the I/O address, with `bus_wdata` equal to the `bus_rdata` of the read cycle. `ack_n` stays 1 throughout.
- R4: In dual address mode with direction 1, the read is at the I/O address and the write is at the memory address.
- R5: In single address mode a transfer is one bus cycle at the memory address with `ack_n` low. `bus_we` is 0 for direction 0 (memory is the source) and 1 for direction 1 (memory is the destination).
- R6: After each transfer the memory address rises by 1 (byte size) or by 2 (word size) when step is 0, and falls by the same amount when step is 1. The I/O address never changes.
- R7: Source code 0001 selects `adc_done`. Codes 0100 and 0101 select `sci_txe[0]` and `sci_rxf[0]`. Codes 0110 and 0111 select `sci_txe[1]` and `sci_rxf[1]`. Codes 1000 to 1101 select `tmr_cap[0]` to `tmr_cap[5]`. Codes 0000, 1110 and 1111 select nothing.
- R8: On a B-side channel (`CHAN_B`=1), code 0010 starts one transfer for each synchronised falling edge of `req_n`. Code 0011 starts transfers back to back while the synchronised `req_n` stays low. On an A-side channel both codes start nothing.
- R9: In sequential mode, the transfer that uses up the count clears `chan_en` and pulses `done_irq` for one cycle. After that, triggers are ignored.
- R10: In repeat mode, the transfer that uses up the count restores the start memory address and the count. No `done_irq` is raised and `chan_en` stays 1.
- R11: A selected strobe that arrives while a transfer is in progress is held as one pending request. The channel serves it right after the current transfer. Further strobes in the same transfer do not add more requests.
- R12: `bus_word` equals the size bit during every bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_we | input | 1 | Load channel setup and enable the channel |
| setup_ctl | input | 8 | Control byte (layout in R2) |
| setup_single | input | 1 | 1 = single address mode, 0 = dual |
| setup_mem | input | AW | Start memory address |
| setup_io | input | AW | Fixed I/O address |
| setup_cnt | input | CW | Transfer count (0 means 2^CW) |
| adc_done | input | 1 | Converter finished strobe |
| sci_txe | input | 2 | Serial port transmit-empty strobes |
| sci_rxf | input | 2 | Serial port receive-full strobes |
| tmr_cap | input | 6 | Timer compare/capture strobes |
| req_n | input | 1 | Asynchronous active-low request pin |
| bus_req | output | 1 | A bus cycle is in progress |
| bus_we | output | 1 | 1 = write cycle |
| bus_word | output | 1 | 1 = 16-bit cycle |
| bus_addr | output | AW | Address of the bus cycle |
| bus_wdata | output | DW | Write data for dual mode |
| bus_rdata | input | DW | Read data, valid in the read cycle |
| ack_n | output | 1 | Active-low acknowledge for single address mode |
| done_irq | output | 1 | One-cycle end-of-block pulse |
| chan_en | output | 1 | Channel enabled |

## Verification
The assertions assume a bus that completes every cycle in one clock, so that `bus_rdata` is valid in the read cycle. They also assume that `setup_we` is never raised while a transfer is in flight. The peripheral strobes are synchronous to `clk`. The bench drives every strobe and setup value on the falling clock edge, and it only reloads the channel once the channel is idle or disabled. It never loads a zero count, and it moves `req_n` only on many-cycle boundaries, so that the number of level-triggered transfers stays within a computable range.

// File: rtl/dma_short_pkg.sv
// Shared types for the short-address-mode DMA channel.
// Assumes: two serial ports and six timer channels feed the trigger decoder.
package dma_short_pkg;

    localparam int NUM_SCI = 2;
    localparam int NUM_TMR = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_SGL  = 2'd3
    } xfer_st_e;

    // Control byte: first member is bit 7.
    typedef struct packed {
        logic       word;
        logic       dec;
        logic       rpt;
        logic       dir;
        logic [3:0] src;
    } chan_ctl_t;

endpackage

// File: rtl/dma_trig_sel.sv
// Trigger selector: synchronises the request pin, finds its falling edge
// and picks the event that the 4-bit source code names.
// Assumes: peripheral strobes are synchronous to clk; req_n is asynchronous.
module dma_trig_sel
    import dma_short_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit CHAN_B      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         src,
    input  logic               adc_done,
    input  logic [NUM_SCI-1:0] sci_txe,
    input  logic [NUM_SCI-1:0] sci_rxf,
    input  logic [NUM_TMR-1:0] tmr_cap,
    input  logic               req_n,
    output logic               evt_hit,
    output logic               lvl_req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_prev;
    logic                   pin_lo;
    logic                   pin_fall;

    // Shift the request pin through the synchroniser and keep its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '1;
            pin_prev <= 1'b1;
        end else begin
            sync_q[0] <= req_n;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            pin_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_lo   = ~sync_q[SYNC_STAGES-1];
    assign pin_fall = pin_prev & pin_lo;

    // Decode the source code into a one-shot hit or a level request.
    always_comb begin
        evt_hit = 1'b0;
        lvl_req = 1'b0;
        case (src)
            4'h1:    evt_hit = adc_done;
            4'h2:    evt_hit = CHAN_B & pin_fall;
            4'h3:    lvl_req = CHAN_B & pin_lo;
            4'h4:    evt_hit = sci_txe[0];
            4'h5:    evt_hit = sci_rxf[0];
            4'h6:    evt_hit = sci_txe[1];
            4'h7:    evt_hit = sci_rxf[1];
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD:
                     evt_hit = tmr_cap[src[2:0]];
            default: evt_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_step_unit.sv
// Memory address stepper: adds or subtracts 1 (byte) or 2 (word).
// Assumes: the address wraps modulo 2^AW.
module dma_step_unit #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_in,
    input  logic          word,
    input  logic          dec,
    output logic [AW-1:0] addr_out
);

    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_W = AW'(2);

    logic [AW-1:0] step;

    // Pick the step size and direction.
    always_comb begin
        step     = word ? STEP_W : STEP_B;
        addr_out = dec ? (addr_in - step) : (addr_in + step);
    end

endmodule

// File: rtl/dma_xfer_count.sv
// Transfer counter: holds the loaded count, counts down per transfer and
// reloads itself when the last transfer of a repeat block completes.
// Assumes: a loaded value of 0 stands for 2^CW transfers.
module dma_xfer_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    input  logic          rpt,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] init_q;

    // Load, count down, or reload in repeat mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            init_q <= '0;
        end else if (load) begin
            cnt_q  <= load_val;
            init_q <= load_val;
        end else if (tick) begin
            cnt_q <= (last && rpt) ? init_q : (cnt_q - ONE);
        end
    end

    assign last = (cnt_q == ONE);

endmodule

// File: rtl/dma_short_chan.sv
// Short-address-mode DMA channel: on each selected trigger it runs one
// transfer (read+write in dual mode, one acknowledged cycle in single mode),
// steps the memory address and counts down. It ends or reloads at count out.
// Assumes: the bus completes each cycle in one clock; setup only when idle.
module dma_short_chan
    import dma_short_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit CHAN_B      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_we,
    input  logic [7:0]         setup_ctl,
    input  logic               setup_single,
    input  logic [AW-1:0]      setup_mem,
    input  logic [AW-1:0]      setup_io,
    input  logic [CW-1:0]      setup_cnt,
    input  logic               adc_done,
    input  logic [NUM_SCI-1:0] sci_txe,
    input  logic [NUM_SCI-1:0] sci_rxf,
    input  logic [NUM_TMR-1:0] tmr_cap,
    input  logic               req_n,
    output logic               bus_req,
    output logic               bus_we,
    output logic               bus_word,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_wdata,
    input  logic [DW-1:0]      bus_rdata,
    output logic               ack_n,
    output logic               done_irq,
    output logic               chan_en
);

    chan_ctl_t     ctl_q;
    logic          single_q;
    logic [AW-1:0] mem_q;
    logic [AW-1:0] mem_init_q;
    logic [AW-1:0] io_q;
    logic [AW-1:0] mem_next;
    logic [DW-1:0] data_q;
    logic          en_q;
    logic          pend_q;
    logic          irq_q;
    xfer_st_e      st_q;
    xfer_st_e      st_d;
    logic          evt_hit;
    logic          lvl_req;
    logic          start;
    logic          finish;
    logic          last;

    dma_trig_sel #(
        .SYNC_STAGES (SYNC_STAGES),
        .CHAN_B      (CHAN_B)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (ctl_q.src),
        .adc_done (adc_done),
        .sci_txe  (sci_txe),
        .sci_rxf  (sci_rxf),
        .tmr_cap  (tmr_cap),
        .req_n    (req_n),
        .evt_hit  (evt_hit),
        .lvl_req  (lvl_req)
    );

    dma_step_unit #(
        .AW (AW)
    ) u_step (
        .addr_in  (mem_q),
        .word     (ctl_q.word),
        .dec      (ctl_q.dec),
        .addr_out (mem_next)
    );

    dma_xfer_count #(
        .CW (CW)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (setup_we),
        .load_val (setup_cnt),
        .tick     (finish && !setup_we),
        .rpt      (ctl_q.rpt),
        .last     (last)
    );

    assign start  = en_q && (st_q == ST_IDLE) && (pend_q || evt_hit || lvl_req);
    assign finish = (st_q == ST_WR) || (st_q == ST_SGL);

    // Next transfer state.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = single_q ? ST_SGL : ST_RD;
            ST_RD:   st_d = ST_WR;
            default: st_d = ST_IDLE;
        endcase
    end

    // Channel state, addresses, pending request and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            single_q   <= 1'b0;
            mem_q      <= '0;
            mem_init_q <= '0;
            io_q       <= '0;
            data_q     <= '0;
            en_q       <= 1'b0;
            pend_q     <= 1'b0;
            irq_q      <= 1'b0;
            st_q       <= ST_IDLE;
        end else if (setup_we) begin
            ctl_q      <= chan_ctl_t'(setup_ctl);
            single_q   <= setup_single;
            mem_q      <= setup_mem;
            mem_init_q <= setup_mem;
            io_q       <= setup_io;
            en_q       <= 1'b1;
            pend_q     <= 1'b0;
            irq_q      <= 1'b0;
            st_q       <= ST_IDLE;
        end else begin
            st_q  <= st_d;
            irq_q <= 1'b0;
            if (st_q == ST_RD) begin
                data_q <= bus_rdata;
            end
            if (start) begin
                pend_q <= pend_q && evt_hit;
            end else if (evt_hit && en_q) begin
                pend_q <= 1'b1;
            end
            if (finish) begin
                mem_q <= (last && ctl_q.rpt) ? mem_init_q : mem_next;
                if (last && !ctl_q.rpt) begin
                    en_q   <= 1'b0;
                    pend_q <= 1'b0;
                    irq_q  <= 1'b1;
                end
            end
        end
    end

    // Bus cycle outputs for the current state.
    always_comb begin
        bus_req  = (st_q != ST_IDLE);
        bus_we   = (st_q == ST_WR) || ((st_q == ST_SGL) && ctl_q.dir);
        bus_word = bus_req && ctl_q.word;
        ack_n    = (st_q != ST_SGL);
        case (st_q)
            ST_RD:   bus_addr = ctl_q.dir ? io_q : mem_q;
            ST_WR:   bus_addr = ctl_q.dir ? mem_q : io_q;
            ST_SGL:  bus_addr = mem_q;
            default: bus_addr = '0;
        endcase
    end

    assign bus_wdata = data_q;
    assign done_irq  = irq_q;
    assign chan_en   = en_q;

endmodule

// File: rtl/dma_short_chan_chk.sv
// Protocol checker for the DMA channel, attached to every instance by bind.
// Assumes: zero-wait bus and no setup while a transfer is in flight.
module dma_short_chan_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic          ack_n,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          done_irq,
    input logic          chan_en
);

    // R5
    ack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> bus_req);

    // R5
    single_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R3
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && ack_n && !bus_we) |=> (bus_req && ack_n && bus_we));

    // R3
    wdata_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && ack_n && bus_we) |-> (bus_wdata == $past(bus_rdata)));

    // R9
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R9
    irq_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !chan_en);

    // R9
    off_stays_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !bus_req) |=> !bus_req);

endmodule

bind dma_short_chan dma_short_chan_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .ack_n     (ack_n),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done_irq  (done_irq),
    .chan_en   (chan_en)
);

// File: tb/dma_short_chan_tb.sv
// Bench: sweeps every size/step/direction/mode combination, every source
// code against every peripheral strobe, and the pin, pending and repeat cases.
module dma_short_chan_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_we = 1'b0;
    logic [7:0]  setup_ctl = '0;
    logic        setup_single = 1'b0;
    logic [15:0] setup_mem = '0;
    logic [15:0] setup_io = '0;
    logic [7:0]  setup_cnt = '0;
    logic [10:0] ev = '0;
    logic        req_n = 1'b1;
    logic [15:0] bus_rdata = '0;

    logic        bus_req, bus_we, bus_word, ack_n, done_irq, chan_en;
    logic [15:0] bus_addr, bus_wdata;
    logic        a_req, a_we, a_word, a_ack_n, a_irq, a_en;
    logic [15:0] a_addr, a_wdata;

    int errors = 0;
    int checks = 0;
    int rd_b = 0;
    int rd_a = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_short_chan u_dut (
        .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .setup_ctl(setup_ctl),
        .setup_single(setup_single), .setup_mem(setup_mem), .setup_io(setup_io),
        .setup_cnt(setup_cnt), .adc_done(ev[0]), .sci_txe({ev[3], ev[1]}),
        .sci_rxf({ev[4], ev[2]}), .tmr_cap(ev[10:5]), .req_n(req_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_n(ack_n), .done_irq(done_irq), .chan_en(chan_en)
    );

    dma_short_chan #(.CHAN_B(1'b0)) u_dut_a (
        .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .setup_ctl(setup_ctl),
        .setup_single(setup_single), .setup_mem(setup_mem), .setup_io(setup_io),
        .setup_cnt(setup_cnt), .adc_done(ev[0]), .sci_txe({ev[3], ev[1]}),
        .sci_rxf({ev[4], ev[2]}), .tmr_cap(ev[10:5]), .req_n(req_n),
        .bus_req(a_req), .bus_we(a_we), .bus_word(a_word),
        .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_rdata(bus_rdata),
        .ack_n(a_ack_n), .done_irq(a_irq), .chan_en(a_en)
    );

    // Count read cycles (one per transfer in dual, and in single direction 0).
    always @(posedge clk) begin
        if (bus_req && !bus_we) rd_b = rd_b + 1;
        if (a_req && !a_we)     rd_a = rd_a + 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [7:0] ctl, input bit single,
                         input logic [15:0] mem, input logic [15:0] io,
                         input logic [7:0] cnt);
        @(negedge clk);
        setup_we = 1'b1; setup_ctl = ctl; setup_single = single;
        setup_mem = mem; setup_io = io; setup_cnt = cnt;
        @(negedge clk);
        setup_we = 1'b0;
    endtask

    // One converter-triggered transfer, started from an idle falling edge.
    task automatic xfer(input bit single, input bit dir, input bit word,
                        input logic [15:0] mem, input logic [15:0] io,
                        input logic [15:0] rval, input string req);
        ev[0] = 1'b1;
        @(negedge clk);
        ev[0] = 1'b0;
        if (single) begin
            chk({req, " single cycle"}, {bus_req, bus_we, ack_n, bus_word, bus_addr},
                {1'b1, dir, 1'b0, word, mem});
        end else begin
            chk({req, " first cycle"}, {bus_req, bus_we, ack_n, bus_word, bus_addr},
                {1'b1, 1'b0, 1'b1, word, dir ? io : mem});
            bus_rdata = rval;
            @(negedge clk);
            chk({req, " second cycle"}, {bus_req, bus_we, ack_n, bus_word, bus_addr},
                {1'b1, 1'b1, 1'b1, word, dir ? mem : io});
            chk({req, " write data"}, bus_wdata, rval);
        end
        @(negedge clk);
    endtask

    initial begin
        int base_b, base_a, mid;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs in reset", {bus_req, ack_n, done_irq, chan_en}, 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {bus_req, ack_n, done_irq, chan_en}, 4'b0100);
        ev = '1;
        @(negedge clk);
        ev = '0;
        chk("R1 strobes ignored before setup", bus_req, 1'b0);

        // R2 R3 R4 R5 R6 R9 R12: every size/step/direction/mode combination.
        for (int cfg = 0; cfg < 16; cfg++) begin
            bit word, dec, dir, single;
            word = cfg[0]; dec = cfg[1]; dir = cfg[2]; single = cfg[3];
            setup({word, dec, 1'b0, dir, 4'h1}, single, 16'h1000, 16'h0040, 8'd3);
            chk("R2 enabled by setup", chan_en, 1'b1);
            for (int k = 0; k < 3; k++) begin
                int stp;
                logic [15:0] em;
                stp = (word ? 2 : 1) * k;
                em = dec ? 16'(32'h1000 - stp) : 16'(32'h1000 + stp);
                xfer(single, dir, word, em, 16'h0040, 16'(16'h5A00 + cfg * 16 + k),
                     single ? "R5 R6 R12" : (dir ? "R4 R6 R12" : "R3 R6 R12"));
            end
            chk("R9 done pulse and disable", {done_irq, chan_en}, 2'b10);
            @(negedge clk);
            chk("R9 done pulse lasts one cycle", done_irq, 1'b0);
            ev[0] = 1'b1;
            @(negedge clk);
            ev[0] = 1'b0;
            chk("R9 trigger ignored after end", bus_req, 1'b0);
        end

        // R7 R8: every source code against every peripheral strobe.
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 11; e++) begin
                int code_of_e;
                bit exp;
                code_of_e = (e == 0) ? 1 : e + 3;
                exp = (c == code_of_e);
                setup(8'(c), 1'b0, 16'h0100, 16'h0010, 8'd1);
                ev = 11'(1 << e);
                @(negedge clk);
                ev = '0;
                chk($sformatf("R7 code %0d strobe %0d B side", c, e), bus_req, exp);
                chk($sformatf("R7 code %0d strobe %0d A side", c, e), a_req, exp);
                repeat (3) @(negedge clk);
            end
        end

        // R8: falling-edge sensing gives one transfer per edge.
        setup(8'h02, 1'b0, 16'h0300, 16'h0020, 8'd20);
        base_b = rd_b; base_a = rd_a;
        req_n = 1'b0;
        repeat (15) @(negedge clk);
        chk("R8 edge gives one transfer", 32'(rd_b - base_b), 32'd1);
        chk("R8 edge reserved on A side", 32'(rd_a - base_a), 32'd0);
        req_n = 1'b1;
        repeat (8) @(negedge clk);

        // R8: level sensing repeats while low and stops after release.
        setup(8'h03, 1'b0, 16'h0300, 16'h0020, 8'd20);
        base_b = rd_b; base_a = rd_a;
        req_n = 1'b0;
        repeat (15) @(negedge clk);
        req_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 level gives 3..6 transfers",
            ((rd_b - base_b) >= 3 && (rd_b - base_b) <= 6), 1'b1);
        chk("R8 level reserved on A side", 32'(rd_a - base_a), 32'd0);
        mid = rd_b;
        repeat (10) @(negedge clk);
        chk("R8 level stops after release", 32'(rd_b - mid), 32'd0);

        // R11: strobes during a transfer leave exactly one pending request.
        setup(8'h01, 1'b0, 16'h0400, 16'h0020, 8'd5);
        base_b = rd_b;
        ev[0] = 1'b1;
        repeat (3) @(negedge clk);
        ev[0] = 1'b0;
        repeat (12) @(negedge clk);
        chk("R11 one pending transfer served", 32'(rd_b - base_b), 32'd2);

        // R10: repeat mode restores the address and count, no done pulse.
        setup(8'hA1, 1'b0, 16'h2000, 16'h0050, 8'd2);
        for (int k = 0; k < 4; k++) begin
            xfer(1'b0, 1'b0, 1'b1, (k % 2 == 0) ? 16'h2000 : 16'h2002, 16'h0050,
                 16'(16'hC000 + k), "R10 repeat address");
            chk("R10 no done pulse in repeat", done_irq, 1'b0);
        end
        chk("R10 channel stays enabled", chan_en, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule